// File: doc/BRIEF.md
# Overlay Channel Alpha Blender

This block lays one source plane over a background pixel stream. Each incoming raster pixel carries its screen coordinates, a source colour with its own alpha byte, and the background colour. When the pixel falls inside a programmed rectangular destination window, and the channel is connected, the block mixes source and background per colour component. Everywhere else the background passes through untouched.

The alpha that weights the mix is picked automatically. If the configured pixel format carries an alpha byte and the global alpha is 255, the pixel alpha is used. If the format carries alpha and the global alpha is below 255, the product of the two is used. If the format has no alpha byte, the global alpha alone is used. Separate over and under coefficient selects let software force either side of the mix to full, zero or the usual complementary weights. The result appears one clock after the input, with a valid flag, a window-hit flag and the chosen alpha mode.

Top module: `ovly_blend`

## Requirements
- R1: While rst_ni is low, and until the first valid input after reset, vld_o, hit_o, mode_o and rgb_o are all zero.
- R2: Every output is registered once: vld_o equals vld_i from the previous clock, and rgb_o, hit_o and mode_o belong to the pixel presented on that same earlier clock.
- R3: The window corners are inclusive. win_xy0_i holds the top-left corner and win_xy1_i the bottom-right corner, each with x in bits 31:16 and y in bits 15:0. A pixel hits when x0 <= pix_x_i <= x1 and y0 <= pix_y_i <= y1.
- R4: For a pixel outside the window, hit_o is 0 and rgb_o equals bg_rgb_i.
- R5: When ch_en_i is 0 or src_sel_i is 0, the channel is disconnected: hit_o is 0 and rgb_o equals bg_rgb_i for every pixel, inside the window or not.
- R6: The format codes on fmt_i are 0 RGB565, 1 BGR565, 2 RGB888, 3 BGR888, 4 XRGB8888, 5 XBGR8888, 6 RGBA8888, 7 BGRA8888, 8 ARGB8888 and 9 ABGR8888. Only codes 6 to 9 carry alpha. mode_o is 0 (global) for a format without alpha, 1 (pixel) for an alpha format with glb_alpha_i = 255, and 2 (combined) for an alpha format with glb_alpha_i < 255. mode_o is never 3.
- R7: The effective alpha a is glb_alpha_i in global mode, src_a_i in pixel mode, and (src_a_i * glb_alpha_i + 127) / 255 (integer division) in combined mode.
- R8: Inside the window with the channel connected, each 8-bit component of rgb_o, packed as R in 23:16, G in 15:8 and B in 7:0, is (src * co + bg * cu + 127) / 255, saturated to 255.
- R9: The over coefficient co is a for ovr_sel_i = 0 or 3, 255 for 1 and 0 for 2. The under coefficient cu is 255 - a for und_sel_i = 0 or 3, 255 for 1 and 0 for 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ch_en_i | input | 1 | Channel enable |
| src_sel_i | input | 3 | Source select; 0 disconnects the channel |
| glb_alpha_i | input | 8 | Global alpha |
| fmt_i | input | 4 | Source pixel format code |
| ovr_sel_i | input | 2 | Over (source) coefficient select |
| und_sel_i | input | 2 | Under (background) coefficient select |
| win_xy0_i | input | 32 | Top-left corner, x in 31:16, y in 15:0 |
| win_xy1_i | input | 32 | Bottom-right corner, x in 31:16, y in 15:0 |
| vld_i | input | 1 | Input pixel valid |
| pix_x_i | input | 16 | Raster x of the pixel |
| pix_y_i | input | 16 | Raster y of the pixel |
| src_a_i | input | 8 | Source pixel alpha |
| src_rgb_i | input | 24 | Source colour, R 23:16, G 15:8, B 7:0 |
| bg_rgb_i | input | 24 | Background colour, same packing |
| vld_o | output | 1 | Output pixel valid |
| hit_o | output | 1 | Pixel was blended (in window and connected) |
| mode_o | output | 2 | Alpha mode used: 0 global, 1 pixel, 2 combined |
| rgb_o | output | 24 | Output colour |

## Verification
Pixels are placed on each inclusive corner and one step outside each edge, which separates an off-by-one in the compare from a correct window and shows whether the bypass really returns the background. Formats are swept across both the alpha-carrying and the alpha-free codes, with global alpha at 255, below 255 and at 0, so that each of the three modes is chosen and a wrong mode rule changes either mode_o or the blended colour. Coefficient selects are driven to full and zero on each side, including both at full with equal colours, which only a saturating adder gets right. Disconnection is tried separately through the enable and through a zero source select, inside the window.

// File: rtl/ovly_pkg.sv
package ovly_pkg;
  typedef enum logic [1:0] {
    AM_GLOBAL   = 2'd0,
    AM_PIXEL    = 2'd1,
    AM_COMBINED = 2'd2
  } amode_e;

  typedef enum logic [1:0] {
    CS_NORM  = 2'd0,
    CS_FULL  = 2'd1,
    CS_ZERO  = 2'd2,
    CS_NORM2 = 2'd3
  } coef_sel_e;

  function automatic logic fmt_has_alpha(input logic [3:0] fmt);
    return (fmt >= 4'd6) && (fmt <= 4'd9);
  endfunction
endpackage

// File: rtl/ovly_win.sv
module ovly_win #(
  parameter int CW = 16
) (
  input  logic [2*CW-1:0] xy0_i,
  input  logic [2*CW-1:0] xy1_i,
  input  logic [CW-1:0]   x_i,
  input  logic [CW-1:0]   y_i,
  output logic            hit_o
);
  logic [CW-1:0] x0, y0, x1, y1;
  assign x0 = xy0_i[2*CW-1:CW];
  assign y0 = xy0_i[CW-1:0];
  assign x1 = xy1_i[2*CW-1:CW];
  assign y1 = xy1_i[CW-1:0];

  logic in_x, in_y;
  assign in_x  = (x_i >= x0) && (x_i <= x1);
  assign in_y  = (y_i >= y0) && (y_i <= y1);
  assign hit_o = in_x && in_y;

  // R3: a hit lies on or between the corners
  always_comb begin
    if (hit_o) a_r3_inside_corners: assert (x_i >= x0 && y_i <= y1);
  end
endmodule

// File: rtl/ovly_alpha.sv
module ovly_alpha
  import ovly_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic [3:0]    fmt_i,
  input  logic [PW-1:0] glb_i,
  input  logic [PW-1:0] pa_i,
  output amode_e        mode_o,
  output logic [PW-1:0] eff_o
);
  localparam int SW = 2*PW + 1;
  localparam logic [SW-1:0] MAXV = SW'((1 << PW) - 1);
  localparam logic [SW-1:0] HALF = SW'(((1 << PW) - 1) / 2);
  localparam logic [PW-1:0] OPAQUE = '1;

  logic          has_a;
  logic [SW-1:0] prod, quo;

  assign has_a = fmt_has_alpha(fmt_i);
  assign prod  = SW'(pa_i) * SW'(glb_i) + HALF;
  assign quo   = prod / MAXV;

  always_comb begin
    if (!has_a)                mode_o = AM_GLOBAL;
    else if (glb_i == OPAQUE)  mode_o = AM_PIXEL;
    else                       mode_o = AM_COMBINED;
  end

  always_comb begin
    unique case (mode_o)
      AM_PIXEL:    eff_o = pa_i;
      AM_COMBINED: eff_o = quo[PW-1:0];
      default:     eff_o = glb_i;
    endcase
  end

  // R7: combined alpha never exceeds either factor
  always_comb begin
    if (mode_o == AM_COMBINED) a_r7_comb_bound: assert (eff_o <= pa_i && eff_o <= glb_i);
  end
endmodule

// File: rtl/ovly_mix.sv
module ovly_mix
  import ovly_pkg::*;
#(
  parameter int PW    = 8,
  parameter int NCOMP = 3
) (
  input  logic [NCOMP*PW-1:0] src_i,
  input  logic [NCOMP*PW-1:0] bg_i,
  input  logic [PW-1:0]       alpha_i,
  input  coef_sel_e           ovr_sel_i,
  input  coef_sel_e           und_sel_i,
  output logic [NCOMP*PW-1:0] mix_o
);
  localparam int SW = 2*PW + 2;
  localparam logic [SW-1:0] MAXV = SW'((1 << PW) - 1);
  localparam logic [SW-1:0] HALF = SW'(((1 << PW) - 1) / 2);
  localparam logic [PW-1:0] FULL = '1;

  logic [PW-1:0] co, cu;

  always_comb begin
    unique case (ovr_sel_i)
      CS_FULL: co = FULL;
      CS_ZERO: co = '0;
      default: co = alpha_i;
    endcase
    unique case (und_sel_i)
      CS_FULL: cu = FULL;
      CS_ZERO: cu = '0;
      default: cu = FULL - alpha_i;
    endcase
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [PW-1:0] s, b;
    logic [SW-1:0] acc, quo;
    assign s   = src_i[c*PW +: PW];
    assign b   = bg_i[c*PW +: PW];
    assign acc = SW'(s) * SW'(co) + SW'(b) * SW'(cu) + HALF;
    assign quo = acc / MAXV;
    assign mix_o[c*PW +: PW] = (quo > MAXV) ? FULL : quo[PW-1:0];

    // R8: complementary weights on equal colours return that colour
    always_comb begin
      if (co + cu == FULL && s == b && co == alpha_i)
        a_r8_equal_in: assert (mix_o[c*PW +: PW] == s);
    end
  end
endmodule

// File: rtl/ovly_blend.sv
module ovly_blend
  import ovly_pkg::*;
#(
  parameter int CW    = 16,
  parameter int PW    = 8,
  parameter int NCOMP = 3,
  parameter int SELW  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ch_en_i,
  input  logic [SELW-1:0]     src_sel_i,
  input  logic [PW-1:0]       glb_alpha_i,
  input  logic [3:0]          fmt_i,
  input  logic [1:0]          ovr_sel_i,
  input  logic [1:0]          und_sel_i,
  input  logic [2*CW-1:0]     win_xy0_i,
  input  logic [2*CW-1:0]     win_xy1_i,
  input  logic                vld_i,
  input  logic [CW-1:0]       pix_x_i,
  input  logic [CW-1:0]       pix_y_i,
  input  logic [PW-1:0]       src_a_i,
  input  logic [NCOMP*PW-1:0] src_rgb_i,
  input  logic [NCOMP*PW-1:0] bg_rgb_i,
  output logic                vld_o,
  output logic                hit_o,
  output logic [1:0]          mode_o,
  output logic [NCOMP*PW-1:0] rgb_o
);
  logic                win_hit, conn, blend_en;
  amode_e              amode;
  logic [PW-1:0]       eff_a;
  logic [NCOMP*PW-1:0] mixed;

  ovly_win #(.CW(CW)) u_win (
    .xy0_i (win_xy0_i),
    .xy1_i (win_xy1_i),
    .x_i   (pix_x_i),
    .y_i   (pix_y_i),
    .hit_o (win_hit)
  );

  ovly_alpha #(.PW(PW)) u_alpha (
    .fmt_i  (fmt_i),
    .glb_i  (glb_alpha_i),
    .pa_i   (src_a_i),
    .mode_o (amode),
    .eff_o  (eff_a)
  );

  ovly_mix #(.PW(PW), .NCOMP(NCOMP)) u_mix (
    .src_i     (src_rgb_i),
    .bg_i      (bg_rgb_i),
    .alpha_i   (eff_a),
    .ovr_sel_i (coef_sel_e'(ovr_sel_i)),
    .und_sel_i (coef_sel_e'(und_sel_i)),
    .mix_o     (mixed)
  );

  assign conn     = ch_en_i && (src_sel_i != '0);
  assign blend_en = conn && win_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      hit_o  <= 1'b0;
      mode_o <= 2'd0;
      rgb_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        hit_o  <= blend_en;
        mode_o <= amode;
        rgb_o  <= blend_en ? mixed : bg_rgb_i;
      end
    end
  end

  a_r2_vld_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r2_vld_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  a_r4_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !win_hit) |=> (!hit_o && rgb_o == $past(bg_rgb_i)));
  a_r5_disconnect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !conn) |=> (!hit_o && rgb_o == $past(bg_rgb_i)));
  a_r6_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

// File: tb/ovly_blend_bench.sv
module ovly_blend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_en = 1'b0;
  logic [2:0]  src_sel = '0;
  logic [7:0]  glb = '0;
  logic [3:0]  fmt = '0;
  logic [1:0]  ovr = '0, und = '0;
  logic [31:0] xy0 = '0, xy1 = '0;
  logic        vld = 1'b0;
  logic [15:0] px = '0, py = '0;
  logic [7:0]  pa = '0;
  logic [23:0] src = '0, bg = '0;
  logic        vld_o, hit_o;
  logic [1:0]  mode_o;
  logic [23:0] rgb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ovly_blend u_ovly_blend (
    .clk_i(clk), .rst_ni(rst_n), .ch_en_i(ch_en), .src_sel_i(src_sel),
    .glb_alpha_i(glb), .fmt_i(fmt), .ovr_sel_i(ovr), .und_sel_i(und),
    .win_xy0_i(xy0), .win_xy1_i(xy1), .vld_i(vld), .pix_x_i(px),
    .pix_y_i(py), .src_a_i(pa), .src_rgb_i(src), .bg_rgb_i(bg),
    .vld_o(vld_o), .hit_o(hit_o), .mode_o(mode_o), .rgb_o(rgb_o)
  );

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
    logic [3:0]  f;
    logic [7:0]  g;
    logic [7:0]  a;
    logic [23:0] s;
    logic [23:0] b;
    logic [1:0]  o;
    logic [1:0]  u;
    logic        eh;
    logic [1:0]  em;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'd10, 16'd20, 4'd8, 8'd255, 8'd128, 24'hFF8040, 24'h000000, 2'd0, 2'd0, 1'b1, 2'd1},
    '{16'd19, 16'd29, 4'd8, 8'd100, 8'd200, 24'h102030, 24'hF0E0D0, 2'd0, 2'd0, 1'b1, 2'd2},
    '{16'd9,  16'd20, 4'd8, 8'd255, 8'd200, 24'h123456, 24'hABCDEF, 2'd0, 2'd0, 1'b0, 2'd1},
    '{16'd20, 16'd29, 4'd4, 8'd80,  8'd10,  24'h123456, 24'h0A0B0C, 2'd0, 2'd0, 1'b0, 2'd0},
    '{16'd15, 16'd19, 4'd6, 8'd255, 8'd90,  24'hFFFFFF, 24'h445566, 2'd0, 2'd0, 1'b0, 2'd1},
    '{16'd15, 16'd30, 4'd9, 8'd10,  8'd90,  24'hFFFFFF, 24'h778899, 2'd0, 2'd0, 1'b0, 2'd2},
    '{16'd12, 16'd25, 4'd4, 8'd80,  8'd255, 24'hFFFFFF, 24'h000000, 2'd0, 2'd0, 1'b1, 2'd0},
    '{16'd12, 16'd25, 4'd0, 8'd255, 8'd0,   24'h5A6B7C, 24'h010203, 2'd0, 2'd0, 1'b1, 2'd0},
    '{16'd13, 16'd22, 4'd7, 8'd0,   8'd255, 24'hFFFFFF, 24'h332211, 2'd0, 2'd0, 1'b1, 2'd2},
    '{16'd11, 16'd21, 4'd9, 8'd255, 8'd0,   24'hFFFFFF, 24'h665544, 2'd3, 2'd3, 1'b1, 2'd1},
    '{16'd14, 16'd24, 4'd2, 8'd128, 8'd0,   24'h405060, 24'hC0C0C0, 2'd1, 2'd2, 1'b1, 2'd0},
    '{16'd14, 16'd24, 4'd5, 8'd128, 8'd0,   24'h405060, 24'hC0C0C0, 2'd2, 2'd1, 1'b1, 2'd0},
    '{16'd16, 16'd27, 4'd8, 8'd200, 8'd255, 24'hFF00FF, 24'h00FF00, 2'd3, 2'd3, 1'b1, 2'd2}
  };

  function automatic int has_alpha(int f);
    return (f == 6 || f == 7 || f == 8 || f == 9) ? 1 : 0;
  endfunction

  function automatic int ref_mode(int f, int g);
    if (has_alpha(f) == 0) return 0;
    return (g == 255) ? 1 : 2;
  endfunction

  function automatic int ref_alpha(int f, int g, int a);
    case (ref_mode(f, g))
      0: return g;
      1: return a;
      default: return (a * g + 127) / 255;
    endcase
  endfunction

  function automatic logic [23:0] ref_rgb(int f, int g, int a, logic [23:0] s,
                                          logic [23:0] b, int o, int u);
    int ea, co, cu, v;
    logic [23:0] r;
    ea = ref_alpha(f, g, a);
    co = (o == 1) ? 255 : (o == 2) ? 0 : ea;
    cu = (u == 1) ? 255 : (u == 2) ? 0 : 255 - ea;
    for (int c = 0; c < 3; c++) begin
      v = (int'(s[c*8 +: 8]) * co + int'(b[c*8 +: 8]) * cu + 127) / 255;
      if (v > 255) v = 255;
      r[c*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive one pixel at a falling edge, sample one cycle later
  task automatic pixel(input logic [15:0] x, input logic [15:0] y, input logic [3:0] f,
                       input logic [7:0] g, input logic [7:0] a, input logic [23:0] s,
                       input logic [23:0] b, input logic [1:0] o, input logic [1:0] u);
    @(negedge clk);
    vld = 1'b1; px = x; py = y; fmt = f; glb = g; pa = a;
    src = s; bg = b; ovr = o; und = u;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    xy0 = {16'd10, 16'd20};
    xy1 = {16'd19, 16'd29};
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 vld_o", 32'(vld_o), 0);
    chk("R1 hit_o", 32'(hit_o), 0);
    chk("R1 mode_o", 32'(mode_o), 0);
    chk("R1 rgb_o", 32'(rgb_o), 0);
    rst_n = 1'b1;
    ch_en = 1'b1;
    src_sel = 3'd1;
    @(negedge clk);
    chk("R2 idle vld_o", 32'(vld_o), 0);

    for (int i = 0; i < NV; i++) begin
      pixel(VECS[i].x, VECS[i].y, VECS[i].f, VECS[i].g, VECS[i].a,
            VECS[i].s, VECS[i].b, VECS[i].o, VECS[i].u);
      chk("R2 vld_o", 32'(vld_o), 1);
      chk("R3 R4 hit_o", 32'(hit_o), 32'(VECS[i].eh));
      chk("R6 mode_o", 32'(mode_o), 32'(VECS[i].em));
      chk("R6 mode_o model", 32'(mode_o), 32'(ref_mode(VECS[i].f, VECS[i].g)));
      if (VECS[i].eh)
        chk("R8 R9 rgb_o", 32'(rgb_o), 32'(ref_rgb(VECS[i].f, VECS[i].g, VECS[i].a,
            VECS[i].s, VECS[i].b, VECS[i].o, VECS[i].u)));
      else
        chk("R4 bypass rgb_o", 32'(rgb_o), 32'(VECS[i].b));
    end

    // R7 combined alpha 128*128 -> 64, white over black gives 64
    pixel(16'd15, 16'd25, 4'd8, 8'd128, 8'd128, 24'hFFFFFF, 24'h000000, 2'd0, 2'd0);
    chk("R7 combined alpha", 32'(rgb_o), 32'h404040);

    // R9 both coefficients full, saturation
    pixel(16'd15, 16'd25, 4'd4, 8'd10, 8'd0, 24'hC8C8C8, 24'hC8C8C8, 2'd1, 2'd1);
    chk("R9 saturate", 32'(rgb_o), 32'hFFFFFF);

    // R8 hand value: global 80 on white over black
    pixel(16'd12, 16'd25, 4'd4, 8'd80, 8'd0, 24'hFFFFFF, 24'h000000, 2'd0, 2'd0);
    chk("R8 global blend", 32'(rgb_o), 32'h505050);

    // R5 disconnect by enable
    ch_en = 1'b0;
    pixel(16'd15, 16'd25, 4'd8, 8'd255, 8'd255, 24'hFFFFFF, 24'h123456, 2'd0, 2'd0);
    chk("R5 en hit_o", 32'(hit_o), 0);
    chk("R5 en rgb_o", 32'(rgb_o), 32'h123456);

    // R5 disconnect by zero source select
    ch_en = 1'b1;
    src_sel = 3'd0;
    pixel(16'd15, 16'd25, 4'd8, 8'd255, 8'd255, 24'hFFFFFF, 24'h654321, 2'd0, 2'd0);
    chk("R5 sel hit_o", 32'(hit_o), 0);
    chk("R5 sel rgb_o", 32'(rgb_o), 32'h654321);

    // R5 reconnect with a different select
    src_sel = 3'd4;
    pixel(16'd15, 16'd25, 4'd8, 8'd255, 8'd255, 24'hABCDEF, 24'h000000, 2'd0, 2'd0);
    chk("R5 reconnect rgb_o", 32'(rgb_o), 32'hABCDEF);

    // R2 valid drops one cycle after input does
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
    chk("R2 vld drop", 32'(vld_o), 0);

    // R1 reset again mid-stream
    rst_n = 1'b0;
    #1;
    chk("R1 async rgb_o", 32'(rgb_o), 0);
    chk("R1 async hit_o", 32'(hit_o), 0);
    summary();
  end
endmodule